// File: doc/BRIEF.md
# Wavefront Ring Pipeline Model

This block is a cycle-based model of a closed ring of handshaking register stages. Every stage is in one of two phases, NULL or DATA, and carries a small data value. On each enabled step, a stage copies the phase and value of its predecessor only if that hand-off cannot erase a wavefront. The copy is allowed when the stage itself and the stage after it both hold the phase opposite to the predecessor's. The predecessor keeps its own contents, as a register would, until its own predecessor overwrites it.

The ring is seeded through a parallel load port with any phase and value pattern. It is then stepped with an enable. Every enabled step reports how many stages copied, and a flag that is raised when the step found nothing that could move. A lap counter tracks a chosen tag value: it counts the DATA wavefronts carrying that tag that cross from the last stage back into stage 0. From these outputs a user can study ring capacity, how many wavefronts advance in parallel, and which patterns lock the ring.

Top module: `wavefront_ring`

## Requirements
- R1: While `rst` is high at a clock edge, every stage becomes NULL (phase bit 0) with value 0, and `moves`, `deadlock` and `laps` become 0.
- R2: When `load_en` is high at a clock edge, stage i takes phase `load_phase[i]` (1 = DATA, 0 = NULL) and value `load_val[i*VAL_W +: VAL_W]`, and `moves`, `deadlock` and `laps` clear to 0. Load takes priority over `step_en`.
- R3: On a step (`step_en` high, `load_en` low), stage i copies the phase and value of stage i-1 (stage 0 copies stage N-1) exactly when the phases of stage i and stage i+1 (modulo N) both differ from the phase of stage i-1. All copies are decided from the phases held before the step and happen together.
- R4: On a cycle with `step_en` and `load_en` both low, every stage keeps its phase and value, and `moves`, `deadlock` and `laps` keep their values.
- R5: After a step, `moves` equals the number of stages that copied in that step.
- R6: After a step, `deadlock` is 1 if no stage copied and 0 otherwise. A step that raises `deadlock` leaves every phase unchanged.
- R7: A step never changes the number of phase boundaries around the ring, and no two neighbouring stages copy in the same step, so `moves` never exceeds N/2.
- R8: `laps` increments by one on every step in which stage 0 copies a DATA phase whose value equals `LAP_TAG` from stage N-1. It wraps modulo 2^LAP_W.
- R9: A ring built with two stages never moves: every step reports 0 moves and raises `deadlock`.
- R10: A five-stage ring holding four wavefronts moves at most one stage per step. An eight-stage ring loaded as two DATA, two NULL, two DATA, two NULL moves four stages on its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Replace the whole ring with the load pattern |
| load_phase | input | N_STAGES | Phase per stage for the load, 1 = DATA |
| load_val | input | N_STAGES*VAL_W | Value per stage for the load, stage i at bits i*VAL_W upward |
| step_en | input | 1 | Advance the ring by one step |
| stage_phase | output | N_STAGES | Current phase of every stage, 1 = DATA |
| stage_val | output | N_STAGES*VAL_W | Current value of every stage |
| moves | output | $clog2(N_STAGES+1) | Stages that copied in the last step |
| deadlock | output | 1 | Last step found no legal move |
| laps | output | LAP_W | Tagged DATA entries into stage 0 |

## Verification
The bench builds three instances with a value width of 4, a lap counter width of 3 and a tag of 0, and gives them ring sizes of 8, 5 and 2. The eight-stage ring exercises the paired pattern in which four wavefronts advance together, an alternating pattern that fills the ring and locks it, and a single travelling DATA block whose repeated laps wrap the narrow counter. The five-stage ring holds four wavefronts, so only one stage can move at a time. The two-stage ring locks on every step. A behavioural model tracks all three instances in step with them.

// File: rtl/wfr_pkg.sv
package wfr_pkg;

    typedef enum logic {
        PH_NULL = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // Index of the stage feeding stage i in a ring of n stages.
    function automatic int ring_prev(input int i, input int n);
        return (i + n - 1) % n;
    endfunction

    // Index of the stage fed by stage i in a ring of n stages.
    function automatic int ring_next(input int i, input int n);
        return (i + 1) % n;
    endfunction

endpackage

// File: rtl/wfr_advance_rule.sv
module wfr_advance_rule
    import wfr_pkg::*;
#(
    parameter int unsigned N_STAGES = 8
) (
    input  logic [N_STAGES-1:0] phase_i,
    output logic [N_STAGES-1:0] take_o
);

    // A stage may copy its predecessor only if it and its successor both
    // hold the opposite phase; otherwise a wavefront would vanish.
    for (genvar g = 0; g < int'(N_STAGES); g++) begin : g_rule
        localparam int PREV = ring_prev(g, int'(N_STAGES));
        localparam int NEXT = ring_next(g, int'(N_STAGES));
        assign take_o[g] = (phase_i[g] != phase_i[PREV]) &&
                           (phase_i[NEXT] != phase_i[PREV]);
    end

endmodule

// File: rtl/wfr_stage.sv
module wfr_stage
    import wfr_pkg::*;
#(
    parameter int unsigned VAL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  phase_e           load_phase,
    input  logic [VAL_W-1:0] load_val,
    input  logic             take,
    input  phase_e           src_phase,
    input  logic [VAL_W-1:0] src_val,
    output phase_e           phase_o,
    output logic [VAL_W-1:0] val_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH_NULL;
            val_o   <= '0;
        end else if (load_en) begin
            phase_o <= load_phase;
            val_o   <= load_val;
        end else if (take) begin
            phase_o <= src_phase;
            val_o   <= src_val;
        end
    end

endmodule

// File: rtl/wfr_step_stats.sv
module wfr_step_stats #(
    parameter int unsigned N_STAGES = 8,
    parameter int unsigned CNT_W    = $clog2(N_STAGES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic                fire,
    input  logic [N_STAGES-1:0] take_i,
    output logic [CNT_W-1:0]    moves_o,
    output logic                deadlock_o
);

    logic [CNT_W-1:0] take_cnt;

    always_comb begin
        take_cnt = '0;
        for (int i = 0; i < int'(N_STAGES); i++) begin
            take_cnt = take_cnt + CNT_W'(take_i[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load_en) begin
            moves_o    <= '0;
            deadlock_o <= 1'b0;
        end else if (fire) begin
            moves_o    <= take_cnt;
            deadlock_o <= (take_cnt == '0);
        end
    end

    AST_MOVES_HALF: assert property (@(posedge clk) disable iff (rst)
        moves_o <= CNT_W'(N_STAGES / 2)); // R7

endmodule

// File: rtl/wfr_lap_tracker.sv
module wfr_lap_tracker
    import wfr_pkg::*;
#(
    parameter int unsigned      VAL_W   = 4,
    parameter int unsigned      LAP_W   = 8,
    parameter logic [VAL_W-1:0] LAP_TAG = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic             enter_take,
    input  phase_e           src_phase,
    input  logic [VAL_W-1:0] src_val,
    output logic [LAP_W-1:0] laps_o
);

    logic tag_enters;

    assign tag_enters = enter_take && (src_phase == PH_DATA) && (src_val == LAP_TAG);

    always_ff @(posedge clk) begin
        if (rst || load_en) begin
            laps_o <= '0;
        end else if (tag_enters) begin
            laps_o <= laps_o + LAP_W'(1);
        end
    end

    AST_LAP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en)) |->
            (laps_o == $past(laps_o) || laps_o == $past(laps_o) + LAP_W'(1))); // R8

endmodule

// File: rtl/wavefront_ring.sv
module wavefront_ring
    import wfr_pkg::*;
#(
    parameter int unsigned      N_STAGES = 8,
    parameter int unsigned      VAL_W    = 4,
    parameter int unsigned      LAP_W    = 8,
    parameter logic [VAL_W-1:0] LAP_TAG  = '0,
    localparam int unsigned     CNT_W    = $clog2(N_STAGES + 1),
    localparam int unsigned     BUS_W    = N_STAGES * VAL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [N_STAGES-1:0] load_phase,
    input  logic [BUS_W-1:0]    load_val,
    input  logic                step_en,
    output logic [N_STAGES-1:0] stage_phase,
    output logic [BUS_W-1:0]    stage_val,
    output logic [CNT_W-1:0]    moves,
    output logic                deadlock,
    output logic [LAP_W-1:0]    laps
);

    phase_e              ph_q  [N_STAGES];
    logic [VAL_W-1:0]    val_q [N_STAGES];
    logic [N_STAGES-1:0] ph_vec;
    logic [N_STAGES-1:0] take_raw;
    logic [N_STAGES-1:0] take_eff;
    logic                fire;

    assign fire     = step_en && !load_en;
    assign take_eff = take_raw & {N_STAGES{fire}};

    wfr_advance_rule #(
        .N_STAGES (N_STAGES)
    ) rule_i (
        .phase_i (ph_vec),
        .take_o  (take_raw)
    );

    for (genvar g = 0; g < int'(N_STAGES); g++) begin : g_stage
        localparam int PREV = ring_prev(g, int'(N_STAGES));

        wfr_stage #(
            .VAL_W (VAL_W)
        ) stage_i (
            .clk        (clk),
            .rst        (rst),
            .load_en    (load_en),
            .load_phase (phase_e'(load_phase[g])),
            .load_val   (load_val[g*VAL_W +: VAL_W]),
            .take       (take_eff[g]),
            .src_phase  (ph_q[PREV]),
            .src_val    (val_q[PREV]),
            .phase_o    (ph_q[g]),
            .val_o      (val_q[g])
        );

        assign ph_vec[g]                    = ph_q[g];
        assign stage_val[g*VAL_W +: VAL_W]  = val_q[g];
    end

    assign stage_phase = ph_vec;

    wfr_step_stats #(
        .N_STAGES (N_STAGES),
        .CNT_W    (CNT_W)
    ) stats_i (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .fire       (fire),
        .take_i     (take_eff),
        .moves_o    (moves),
        .deadlock_o (deadlock)
    );

    wfr_lap_tracker #(
        .VAL_W   (VAL_W),
        .LAP_W   (LAP_W),
        .LAP_TAG (LAP_TAG)
    ) laps_i (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .enter_take (take_eff[0]),
        .src_phase  (ph_q[N_STAGES-1]),
        .src_val    (val_q[N_STAGES-1]),
        .laps_o     (laps)
    );

    // Number of phase boundaries around the ring, for the ordering check.
    int bnd_cnt;
    always_comb begin
        bnd_cnt = 0;
        for (int i = 0; i < int'(N_STAGES); i++) begin
            if (ph_vec[i] != ph_vec[(i + 1) % int'(N_STAGES)]) begin
                bnd_cnt = bnd_cnt + 1;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stage_phase == '0 && stage_val == '0 && laps == '0)); // R1

    AST_LOAD_APPLIES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_en)) |->
            (stage_phase == $past(load_phase) && stage_val == $past(load_val))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en) && !$past(step_en)) |->
            (stage_phase == $past(stage_phase) && stage_val == $past(stage_val))); // R4

    AST_DEADLOCK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $rose(deadlock) |-> stage_phase == $past(stage_phase)); // R6

    AST_RING_BOUNDARIES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fire)) |-> bnd_cnt == $past(bnd_cnt)); // R7

endmodule

// File: tb/wavefront_ring_tb_top.sv
module wavefront_ring_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_en = 1'b0;
    logic step_en = 1'b0;
    logic [7:0]  ld_ph  [3];
    logic [31:0] ld_val [3];

    logic [7:0]  ph8;  logic [31:0] val8; logic [3:0] mv8; logic dl8; logic [2:0] lap8;
    logic [4:0]  ph5;  logic [19:0] val5; logic [2:0] mv5; logic dl5; logic [2:0] lap5;
    logic [1:0]  ph2;  logic [7:0]  val2; logic [1:0] mv2; logic dl2; logic [2:0] lap2;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wavefront_ring #(.N_STAGES(8), .VAL_W(4), .LAP_W(3), .LAP_TAG(4'd0)) dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_phase(ld_ph[0]),
        .load_val(ld_val[0]), .step_en(step_en), .stage_phase(ph8),
        .stage_val(val8), .moves(mv8), .deadlock(dl8), .laps(lap8));

    wavefront_ring #(.N_STAGES(5), .VAL_W(4), .LAP_W(3), .LAP_TAG(4'd0)) dut5_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_phase(ld_ph[1][4:0]),
        .load_val(ld_val[1][19:0]), .step_en(step_en), .stage_phase(ph5),
        .stage_val(val5), .moves(mv5), .deadlock(dl5), .laps(lap5));

    wavefront_ring #(.N_STAGES(2), .VAL_W(4), .LAP_W(3), .LAP_TAG(4'd0)) dut2_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_phase(ld_ph[2][1:0]),
        .load_val(ld_val[2][7:0]), .step_en(step_en), .stage_phase(ph2),
        .stage_val(val2), .moves(mv2), .deadlock(dl2), .laps(lap2));

    // Outputs gathered per instance, padded to the largest ring.
    logic [7:0]  a_ph  [3];
    logic [31:0] a_val [3];
    int          a_mv  [3];
    logic        a_dl  [3];
    int          a_lap [3];

    always_comb begin
        a_ph[0] = ph8;            a_val[0] = val8;
        a_ph[1] = {3'b0, ph5};    a_val[1] = {12'b0, val5};
        a_ph[2] = {6'b0, ph2};    a_val[2] = {24'b0, val2};
        a_mv[0] = int'(mv8);      a_mv[1] = int'(mv5);      a_mv[2] = int'(mv2);
        a_dl[0] = dl8;            a_dl[1] = dl5;            a_dl[2] = dl2;
        a_lap[0] = int'(lap8);    a_lap[1] = int'(lap5);    a_lap[2] = int'(lap2);
    end

    // Behavioural reference state.
    int n_of [3] = '{8, 5, 2};
    int m_ph  [3][8];
    int m_dv  [3][8];
    int m_mv  [3];
    bit m_dl  [3];
    int m_lap [3];

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 8; i++) begin
                m_ph[k][i] = 0;
                m_dv[k][i] = 0;
            end
            m_mv[k] = 0; m_dl[k] = 1'b0; m_lap[k] = 0;
        end
    endtask

    task automatic model_load(input int k);
        for (int i = 0; i < n_of[k]; i++) begin
            m_ph[k][i] = int'(ld_ph[k][i]);
            m_dv[k][i] = int'(ld_val[k][i*4 +: 4]);
        end
        m_mv[k] = 0; m_dl[k] = 1'b0; m_lap[k] = 0;
    endtask

    task automatic model_step(input int k);
        int n;
        int nph [8];
        int ndv [8];
        int mv;
        n  = n_of[k];
        mv = 0;
        for (int i = 0; i < n; i++) begin
            int src;
            int nxt;
            src = (i + n - 1) % n;
            nxt = (i + 1) % n;
            nph[i] = m_ph[k][i];
            ndv[i] = m_dv[k][i];
            if (m_ph[k][i] != m_ph[k][src] && m_ph[k][nxt] != m_ph[k][src]) begin
                nph[i] = m_ph[k][src];
                ndv[i] = m_dv[k][src];
                mv++;
                if (i == 0 && m_ph[k][src] == 1 && m_dv[k][src] == 0)
                    m_lap[k] = (m_lap[k] + 1) % 8;
            end
        end
        for (int i = 0; i < n; i++) begin
            m_ph[k][i] = nph[i];
            m_dv[k][i] = ndv[i];
        end
        m_mv[k] = mv;
        m_dl[k] = (mv == 0);
    endtask

    task automatic compare_all();
        for (int k = 0; k < 3; k++) begin
            logic [7:0]  eph;
            logic [31:0] ev;
            eph = '0;
            ev  = '0;
            for (int i = 0; i < n_of[k]; i++) begin
                eph[i]       = m_ph[k][i][0];
                ev[i*4 +: 4] = m_dv[k][i][3:0];
            end
            check(a_ph[k] == eph, "R3", $sformatf("ring%0d phases", n_of[k]), 64'(a_ph[k]), 64'(eph));
            check(a_val[k] == ev, "R3", $sformatf("ring%0d values", n_of[k]), 64'(a_val[k]), 64'(ev));
            check(a_mv[k] == m_mv[k], "R5", $sformatf("ring%0d moves", n_of[k]), 64'(a_mv[k]), 64'(m_mv[k]));
            check(a_dl[k] == m_dl[k], "R6", $sformatf("ring%0d deadlock", n_of[k]), 64'(a_dl[k]), 64'(m_dl[k]));
            check(a_lap[k] == m_lap[k], "R8", $sformatf("ring%0d laps", n_of[k]), 64'(a_lap[k]), 64'(m_lap[k]));
        end
    endtask

    // Called at a falling edge: drive, predict, let one rising edge pass,
    // then compare at the next falling edge.
    task automatic tick(input bit ld, input bit st);
        load_en = ld;
        step_en = st;
        for (int k = 0; k < 3; k++) begin
            if (ld) model_load(k);
            else if (st) model_step(k);
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    function automatic int boundaries(input logic [7:0] ph, input int n);
        int c;
        c = 0;
        for (int i = 0; i < n; i++) if (ph[i] != ph[(i + 1) % n]) c++;
        return c;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stimulus
        logic [7:0]  held_ph;
        logic [31:0] held_val;
        int b0;

        for (int k = 0; k < 3; k++) begin
            ld_ph[k]  = '0;
            ld_val[k] = '0;
        end
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(ph8 == 8'h00 && val8 == 32'h0, "R1", "reset stages", 64'({ph8, val8}), 64'h0);
        check(mv8 == 4'd0 && dl8 == 1'b0 && lap8 == 3'd0, "R1", "reset status",
              64'({mv8, dl8, lap8}), 64'h0);
        compare_all();

        // Paired pattern on 8 stages, four wavefronts on 5 stages, 2-stage lock.
        ld_ph[0] = 8'h33; ld_val[0] = 32'h0055_0000;
        ld_ph[1] = 8'h0B; ld_val[1] = 32'h0000_7000;
        ld_ph[2] = 8'h01; ld_val[2] = 32'h0000_0090;
        tick(1'b1, 1'b0);
        check(ph8 == 8'h33 && val8 == 32'h0055_0000, "R2", "load pattern",
              64'({ph8, val8}), 64'({8'h33, 32'h0055_0000}));

        b0 = boundaries(ph8, 8);
        tick(1'b0, 1'b1);
        check(mv8 == 4'd4, "R10", "paired ring first step moves", 64'(mv8), 64'd4);
        check(mv5 <= 3'd1, "R10", "five-stage moves", 64'(mv5), 64'd1);
        check(dl2 == 1'b1 && mv2 == 2'd0, "R9", "two-stage lock", 64'({mv2, dl2}), 64'h1);
        check(boundaries(ph8, 8) == b0, "R7", "boundaries after step",
              64'(boundaries(ph8, 8)), 64'(b0));

        for (int j = 0; j < 40; j++) begin
            if (j % 5 == 4) begin
                held_ph  = ph8;
                held_val = val8;
                tick(1'b0, 1'b0);
                check(ph8 == held_ph && val8 == held_val, "R4", "idle hold",
                      64'({ph8, val8}), 64'({held_ph, held_val}));
            end else begin
                b0 = boundaries(ph8, 8);
                tick(1'b0, 1'b1);
                check(boundaries(ph8, 8) == b0, "R7", "boundaries kept",
                      64'(boundaries(ph8, 8)), 64'(b0));
                check(mv5 <= 3'd1, "R10", "five-stage single move", 64'(mv5), 64'd1);
                check(dl2 == 1'b1, "R9", "two-stage stays locked", 64'(dl2), 64'd1);
            end
        end

        // Load with step also high: load wins. Single DATA block, tag value 0.
        ld_ph[0] = 8'h01; ld_val[0] = 32'h0;
        tick(1'b1, 1'b1);
        check(ph8 == 8'h01 && lap8 == 3'd0, "R2", "load over step",
              64'({ph8, lap8}), 64'({8'h01, 3'd0}));

        for (int j = 0; j < 80; j++) begin
            tick(1'b0, 1'b1);
        end
        check(m_lap[0] != 0, "R8", "laps counted after wrap", 64'(lap8), 64'(m_lap[0]));

        // Alternating pattern fills the ring: no move possible.
        ld_ph[0] = 8'h55; ld_val[0] = 32'h1234_5678;
        tick(1'b1, 1'b0);
        held_ph = ph8;
        tick(1'b0, 1'b1);
        check(dl8 == 1'b1 && mv8 == 4'd0, "R6", "full ring deadlock", 64'({mv8, dl8}), 64'h1);
        check(ph8 == held_ph, "R6", "deadlock leaves phases", 64'(ph8), 64'(held_ph));
        tick(1'b0, 1'b0);
        check(dl8 == 1'b1, "R4", "deadlock held while idle", 64'(dl8), 64'd1);

        ld_ph[0] = 8'h33; ld_val[0] = 32'h0;
        tick(1'b1, 1'b0);
        check(dl8 == 1'b0, "R2", "load clears deadlock", 64'(dl8), 64'd0);
        tick(1'b0, 1'b1);
        check(dl8 == 1'b0 && mv8 == 4'd4, "R6", "moving step clears deadlock",
              64'({mv8, dl8}), 64'({4'd4, 1'b0}));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule